// File: doc/BRIEF.md
# Small-Batch Pixel Thread Scheduler

This block keeps a table of pixel threads and decides, every clock, which thread sends an instruction to the arithmetic unit and which one sends a fetch to the texture unit. A thread is one batch of 16 pixels, organised as four 2x2 quads with one quad per quad pipeline. A per-quad coverage mask travels with it. Because batches are this small and the table holds up to 512 of them, the scheduler can move to a different thread on every cycle at no cost.

Arithmetic and texture work leave through two independent valid/ready issue ports. A thread that sends a texture fetch is parked until the sampler reports completion for its thread number, which can take many cycles. During that time the arithmetic port keeps issuing from other ready threads, so sampler latency is hidden behind useful math. The class of each thread's current instruction (arithmetic, texture or end) is loaded at allocation. After that, it is supplied by the instruction side in the same cycle as each issue, as the class of the following instruction. A thread whose next instruction is the end becomes done, and the retire input then frees its slot.

New threads enter through a valid/ready allocation port. A transfer happens only on a cycle where both valid and ready are high. The allocation port's ready drops when every slot is taken. Each issue port holds its offer while its ready is low. The texture-completion and retire inputs are single-cycle valid pulses that cannot be back-pressured.

Top module: `pixel_thread_sched`

## Requirements
- R1: After reset every slot is free. alloc_ready is 1, alloc_tid is 0, and alu_valid and tex_valid are 0.
- R2: alloc_ready is low exactly when all NUM_THREADS slots are occupied. alloc_tid always shows the lowest-numbered free slot. An allocation handshake loads that slot with alloc_batch, alloc_ip, alloc_qmask and the class alloc_op. The slot becomes ready, or done if the class is end.
- R3: The ALU port offers only a ready thread whose current class is arithmetic. The texture port offers only a ready thread whose current class is texture. Each port issues at most one thread per cycle, and the two ports never show the same thread. Each offer carries the thread's tid, batch, instruction pointer and quad mask.
- R4: Each port uses its own round-robin order. The search starts at the slot after the last thread issued on that port and wraps at NUM_THREADS. Both orders start at slot 0.
- R5: An issue advances the thread's instruction pointer by 1. The thread's class becomes the code on that port's next_op input: 0 arithmetic, 1 texture, 2 or 3 end. A different thread may issue on the very next cycle.
- R6: An ALU issue leaves the thread ready, or done if next_op is end. A texture issue parks the thread in the texture-wait state.
- R7: A texdone pulse for a parked thread makes it ready on the next cycle, or done if its class is end. A texdone pulse for a thread in any other state is ignored.
- R8: Parked threads never hold back ALU issue from other threads.
- R9: A retire pulse for a done thread frees its slot. A retire pulse for a thread that is not done is ignored.
- R10: While a port's valid is high and its ready is low, no thread state changes through that port. The port's valid stays high on the next cycle.
- R11: When allocation and retire fall in the same cycle, the allocation uses only slots that were free before that cycle. The retired slot becomes allocatable on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | New thread offered |
| alloc_ready | output | 1 | A slot is free |
| alloc_batch | input | BATCH_W | Batch identifier of the new thread |
| alloc_ip | input | IP_W | Starting instruction pointer |
| alloc_qmask | input | QUADS | Live quads of the batch |
| alloc_op | input | 2 | Class of the first instruction |
| alloc_tid | output | TID_W | Slot the next allocation takes |
| alu_valid | output | 1 | Arithmetic issue offered |
| alu_ready | input | 1 | Arithmetic unit accepts |
| alu_tid | output | TID_W | Issuing thread |
| alu_batch | output | BATCH_W | Batch of issuing thread |
| alu_ip | output | IP_W | Instruction pointer issued |
| alu_qmask | output | QUADS | Quad mask of issuing thread |
| alu_next_op | input | 2 | Class of the instruction after the one issued |
| tex_valid | output | 1 | Texture issue offered |
| tex_ready | input | 1 | Texture unit accepts |
| tex_tid | output | TID_W | Issuing thread |
| tex_batch | output | BATCH_W | Batch of issuing thread |
| tex_ip | output | IP_W | Instruction pointer issued |
| tex_qmask | output | QUADS | Quad mask of issuing thread |
| tex_next_op | input | 2 | Class of the instruction after the one issued |
| texdone_valid | input | 1 | Texture result returned |
| texdone_tid | input | TID_W | Thread whose fetch completed |
| retire_valid | input | 1 | Retire pulse |
| retire_tid | input | TID_W | Thread to free |

## Verification
Allocation and retirement can land in the same cycle. The retiring slot must not be handed out until the cycle after. The bench provokes this with a directed sequence. First it fills the whole table while holding both issue ports stalled. Then it drains every thread to done while allocation stays requested. Finally it retires one thread. It judges that alloc_ready is still low in the retire cycle and that, one cycle later, alloc_ready is high and alloc_tid names exactly the retired slot. The random phase also lets texture completions, retires and both issue handshakes coincide. A reference table in the bench checks every port on every cycle.

// File: rtl/pts_pkg.sv
package pts_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_READY = 2'd1,
    SLOT_WAIT  = 2'd2,
    SLOT_DONE  = 2'd3
  } slot_state_e;

  typedef enum logic [1:0] {
    OPC_ALU = 2'd0,
    OPC_TEX = 2'd1,
    OPC_END = 2'd2
  } op_class_e;

  function automatic op_class_e decode_op(input logic [1:0] code);
    if (code[1])      return OPC_END;
    else if (code[0]) return OPC_TEX;
    else              return OPC_ALU;
  endfunction

endpackage

// File: rtl/pts_rr_pick.sv
module pts_rr_pick #(
  parameter int N     = 512,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] start,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // search from start upward, wrapping at N; first hit wins
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      int j;
      j = int'(start) + i;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any = 1'b1;
        idx = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/pts_slot.sv
module pts_slot
  import pts_pkg::*;
#(
  parameter int BATCH_W = 12,
  parameter int IP_W    = 10,
  parameter int QUADS   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [1:0]         load_op,
  input  logic [BATCH_W-1:0] load_batch,
  input  logic [IP_W-1:0]    load_ip,
  input  logic [QUADS-1:0]   load_qmask,
  input  logic               alu_hit,
  input  logic [1:0]         alu_nop,
  input  logic               tex_hit,
  input  logic [1:0]         tex_nop,
  input  logic               wake_hit,
  input  logic               free_hit,
  output slot_state_e        state,
  output op_class_e          op,
  output logic [BATCH_W-1:0] batch,
  output logic [IP_W-1:0]    ip,
  output logic [QUADS-1:0]   qmask
);
  op_class_e load_cls, alu_cls, tex_cls;

  assign load_cls = decode_op(load_op);
  assign alu_cls  = decode_op(alu_nop);
  assign tex_cls  = decode_op(tex_nop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SLOT_FREE;
      op    <= OPC_ALU;
      batch <= '0;
      ip    <= '0;
      qmask <= '0;
    end else if (load) begin
      state <= (load_cls == OPC_END) ? SLOT_DONE : SLOT_READY;
      op    <= load_cls;
      batch <= load_batch;
      ip    <= load_ip;
      qmask <= load_qmask;
    end else if (alu_hit) begin
      ip    <= ip + 1'b1;
      op    <= alu_cls;
      state <= (alu_cls == OPC_END) ? SLOT_DONE : SLOT_READY;
    end else if (tex_hit) begin
      ip    <= ip + 1'b1;
      op    <= tex_cls;
      state <= SLOT_WAIT;
    end else if (wake_hit && state == SLOT_WAIT) begin
      state <= (op == OPC_END) ? SLOT_DONE : SLOT_READY;
    end else if (free_hit && state == SLOT_DONE) begin
      state <= SLOT_FREE;
    end
  end
endmodule

// File: rtl/pixel_thread_sched.sv
module pixel_thread_sched
  import pts_pkg::*;
#(
  parameter int NUM_THREADS = 512,
  parameter int BATCH_W     = 12,
  parameter int IP_W        = 10,
  parameter int QUADS       = 4,
  parameter int TID_W       = $clog2(NUM_THREADS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  output logic               alloc_ready,
  input  logic [BATCH_W-1:0] alloc_batch,
  input  logic [IP_W-1:0]    alloc_ip,
  input  logic [QUADS-1:0]   alloc_qmask,
  input  logic [1:0]         alloc_op,
  output logic [TID_W-1:0]   alloc_tid,
  output logic               alu_valid,
  input  logic               alu_ready,
  output logic [TID_W-1:0]   alu_tid,
  output logic [BATCH_W-1:0] alu_batch,
  output logic [IP_W-1:0]    alu_ip,
  output logic [QUADS-1:0]   alu_qmask,
  input  logic [1:0]         alu_next_op,
  output logic               tex_valid,
  input  logic               tex_ready,
  output logic [TID_W-1:0]   tex_tid,
  output logic [BATCH_W-1:0] tex_batch,
  output logic [IP_W-1:0]    tex_ip,
  output logic [QUADS-1:0]   tex_qmask,
  input  logic [1:0]         tex_next_op,
  input  logic               texdone_valid,
  input  logic [TID_W-1:0]   texdone_tid,
  input  logic               retire_valid,
  input  logic [TID_W-1:0]   retire_tid
);
  localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THREADS - 1);

  slot_state_e        st_a    [NUM_THREADS];
  op_class_e          op_a    [NUM_THREADS];
  logic [BATCH_W-1:0] batch_a [NUM_THREADS];
  logic [IP_W-1:0]    ip_a    [NUM_THREADS];
  logic [QUADS-1:0]   qmask_a [NUM_THREADS];

  logic [NUM_THREADS-1:0]   free_req, alu_req, tex_req;
  logic [2*NUM_THREADS-1:0] slot_state_flat;
  logic [TID_W-1:0]         alu_ptr, tex_ptr;
  logic                     alloc_fire, alu_fire, tex_fire;

  assign alloc_fire = alloc_valid && alloc_ready;
  assign alu_fire   = alu_valid && alu_ready;
  assign tex_fire   = tex_valid && tex_ready;

  for (genvar k = 0; k < NUM_THREADS; k++) begin : g_slot
    localparam logic [TID_W-1:0] MY_TID = TID_W'(k);

    pts_slot #(
      .BATCH_W(BATCH_W), .IP_W(IP_W), .QUADS(QUADS)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (alloc_fire && alloc_tid == MY_TID),
      .load_op   (alloc_op),
      .load_batch(alloc_batch),
      .load_ip   (alloc_ip),
      .load_qmask(alloc_qmask),
      .alu_hit   (alu_fire && alu_tid == MY_TID),
      .alu_nop   (alu_next_op),
      .tex_hit   (tex_fire && tex_tid == MY_TID),
      .tex_nop   (tex_next_op),
      .wake_hit  (texdone_valid && texdone_tid == MY_TID),
      .free_hit  (retire_valid && retire_tid == MY_TID),
      .state     (st_a[k]),
      .op        (op_a[k]),
      .batch     (batch_a[k]),
      .ip        (ip_a[k]),
      .qmask     (qmask_a[k])
    );

    assign free_req[k] = (st_a[k] == SLOT_FREE);
    assign alu_req[k]  = (st_a[k] == SLOT_READY) && (op_a[k] == OPC_ALU);
    assign tex_req[k]  = (st_a[k] == SLOT_READY) && (op_a[k] == OPC_TEX);
    assign slot_state_flat[2*k +: 2] = st_a[k];
  end

  // lowest free slot: fixed start at 0
  pts_rr_pick #(.N(NUM_THREADS), .IDX_W(TID_W)) u_free_pick (
    .req(free_req), .start('0), .any(alloc_ready), .idx(alloc_tid)
  );

  pts_rr_pick #(.N(NUM_THREADS), .IDX_W(TID_W)) u_alu_pick (
    .req(alu_req), .start(alu_ptr), .any(alu_valid), .idx(alu_tid)
  );

  pts_rr_pick #(.N(NUM_THREADS), .IDX_W(TID_W)) u_tex_pick (
    .req(tex_req), .start(tex_ptr), .any(tex_valid), .idx(tex_tid)
  );

  assign alu_batch = batch_a[alu_tid];
  assign alu_ip    = ip_a[alu_tid];
  assign alu_qmask = qmask_a[alu_tid];
  assign tex_batch = batch_a[tex_tid];
  assign tex_ip    = ip_a[tex_tid];
  assign tex_qmask = qmask_a[tex_tid];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alu_ptr <= '0;
      tex_ptr <= '0;
    end else begin
      if (alu_fire) alu_ptr <= (alu_tid == LAST_TID) ? '0 : alu_tid + 1'b1;
      if (tex_fire) tex_ptr <= (tex_tid == LAST_TID) ? '0 : tex_tid + 1'b1;
    end
  end
endmodule

// File: rtl/pixel_thread_sched_chk.sv
module pixel_thread_sched_chk
  import pts_pkg::*;
#(
  parameter int NUM_THREADS = 512,
  parameter int TID_W       = $clog2(NUM_THREADS)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     alloc_valid,
  input logic                     alloc_ready,
  input logic [TID_W-1:0]         alloc_tid,
  input logic                     alu_valid,
  input logic                     alu_ready,
  input logic [TID_W-1:0]         alu_tid,
  input logic                     tex_valid,
  input logic                     tex_ready,
  input logic [TID_W-1:0]         tex_tid,
  input logic                     texdone_valid,
  input logic [TID_W-1:0]         texdone_tid,
  input logic                     retire_valid,
  input logic [TID_W-1:0]         retire_tid,
  input logic [2*NUM_THREADS-1:0] slot_state_flat
);
  function automatic logic [1:0] st_at(input logic [2*NUM_THREADS-1:0] v,
                                       input logic [TID_W-1:0] t);
    return v[{t, 1'b0} +: 2];
  endfunction

  logic             seen_alloc, seen_alu, seen_tex, seen_wake, seen_free;
  logic [TID_W-1:0] id_alloc, id_alu, id_tex, id_wake, id_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_alloc <= 1'b0; seen_alu <= 1'b0; seen_tex <= 1'b0;
      seen_wake  <= 1'b0; seen_free <= 1'b0;
      id_alloc <= '0; id_alu <= '0; id_tex <= '0; id_wake <= '0; id_free <= '0;
    end else begin
      seen_alloc <= alloc_valid && alloc_ready;
      seen_alu   <= alu_valid && alu_ready;
      seen_tex   <= tex_valid && tex_ready;
      seen_wake  <= texdone_valid && st_at(slot_state_flat, texdone_tid) == SLOT_WAIT;
      seen_free  <= retire_valid && st_at(slot_state_flat, retire_tid) == SLOT_DONE;
      id_alloc <= alloc_tid;
      id_alu   <= alu_tid;
      id_tex   <= tex_tid;
      id_wake  <= texdone_tid;
      id_free  <= retire_tid;
    end
  end

  // R3
  port_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_valid && tex_valid |-> alu_tid != tex_tid);

  // R10
  alu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_valid && !alu_ready |=> alu_valid);

  // R10
  tex_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tex_valid && !tex_ready |=> tex_valid);

  // R2
  alloc_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_alloc |-> st_at(slot_state_flat, id_alloc) != SLOT_FREE);

  // R6
  alu_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_alu |-> (st_at(slot_state_flat, id_alu) == SLOT_READY ||
                  st_at(slot_state_flat, id_alu) == SLOT_DONE));

  // R6
  tex_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_tex |-> st_at(slot_state_flat, id_tex) == SLOT_WAIT);

  // R7
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_wake |-> (st_at(slot_state_flat, id_wake) == SLOT_READY ||
                   st_at(slot_state_flat, id_wake) == SLOT_DONE));

  // R9
  free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_free |-> st_at(slot_state_flat, id_free) == SLOT_FREE);
endmodule

bind pixel_thread_sched pixel_thread_sched_chk #(
  .NUM_THREADS(NUM_THREADS), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tid(alloc_tid),
  .alu_valid(alu_valid), .alu_ready(alu_ready), .alu_tid(alu_tid),
  .tex_valid(tex_valid), .tex_ready(tex_ready), .tex_tid(tex_tid),
  .texdone_valid(texdone_valid), .texdone_tid(texdone_tid),
  .retire_valid(retire_valid), .retire_tid(retire_tid),
  .slot_state_flat(slot_state_flat)
);

// File: tb/pixel_thread_sched_bench.sv
module pixel_thread_sched_bench;
  localparam int N = 16, TW = 4, BW = 12, IW = 10, QW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_ready;
  logic [BW-1:0] alloc_batch = '0;
  logic [IW-1:0] alloc_ip = '0;
  logic [QW-1:0] alloc_qmask = '0;
  logic [1:0] alloc_op = '0;
  logic [TW-1:0] alloc_tid;
  logic alu_valid, alu_ready = 0, tex_valid, tex_ready = 0;
  logic [TW-1:0] alu_tid, tex_tid;
  logic [BW-1:0] alu_batch, tex_batch;
  logic [IW-1:0] alu_ip, tex_ip;
  logic [QW-1:0] alu_qmask, tex_qmask;
  logic [1:0] alu_next_op = '0, tex_next_op = '0;
  logic texdone_valid = 0, retire_valid = 0;
  logic [TW-1:0] texdone_tid = '0, retire_tid = '0;

  always #4 clk = ~clk;

  pixel_thread_sched #(.NUM_THREADS(N), .BATCH_W(BW), .IP_W(IW), .QUADS(QW)) u_pixel_thread_sched (.*);

  int checks = 0, errors = 0;
  // reference table: state 0 free, 1 ready, 2 texture wait, 3 done
  int m_st [N];
  logic [1:0] m_op [N];
  logic [BW-1:0] m_b [N];
  logic [IW-1:0] m_ip [N];
  logic [QW-1:0] m_q [N];
  int p_alu = 0, p_tex = 0;
  int overlap = 0, switches = 0, prev_alu = -1, last_ret = -1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // program model: class of the instruction at ip for a batch
  function automatic logic [1:0] cls(input logic [BW-1:0] b, input logic [IW-1:0] ip);
    int v = int'(ip);
    if (v % 7 == 6) return 2'd2;
    if ((v + int'(b)) % 3 == 0) return 2'd1;
    return 2'd0;
  endfunction

  function automatic int pick(input logic [1:0] want, input int ptr);
    for (int i = 0; i < N; i++) begin
      int j = (ptr + i) % N;
      if (m_st[j] == 1 && m_op[j] == want) return j;
    end
    return -1;
  endfunction

  function automatic int lowest_free();
    for (int i = 0; i < N; i++) if (m_st[i] == 0) return i;
    return -1;
  endfunction

  function automatic int rand_in(input int s);
    int b = $urandom_range(0, N-1);
    for (int i = 0; i < N; i++) if (m_st[(b + i) % N] == s) return (b + i) % N;
    return -1;
  endfunction

  function automatic bit any_wait();
    for (int i = 0; i < N; i++) if (m_st[i] == 2) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input int apct, input int upct, input int tpct, input int dpct, input int rpct);
    int ef, ea, et, d, r;
    bit af, uf, tf, dk, rk;
    @(negedge clk);
    ef = lowest_free(); ea = pick(2'd0, p_alu); et = pick(2'd1, p_tex);
    chk(alloc_ready == (ef >= 0), "R2 alloc_ready", alloc_ready, ef >= 0);
    if (ef >= 0) chk(alloc_tid == TW'(ef), "R2 alloc_tid", alloc_tid, ef);
    chk(alu_valid == (ea >= 0), "R3 alu_valid", alu_valid, ea >= 0);
    if (ea >= 0) begin
      chk(alu_tid == TW'(ea), "R4 alu_tid order", alu_tid, ea);
      chk({alu_batch, alu_ip, alu_qmask} == {m_b[ea], m_ip[ea], m_q[ea]}, "R3 alu fields",
          {alu_batch, alu_ip, alu_qmask}, {m_b[ea], m_ip[ea], m_q[ea]});
    end
    chk(tex_valid == (et >= 0), "R3 tex_valid", tex_valid, et >= 0);
    if (et >= 0) begin
      chk(tex_tid == TW'(et), "R4 tex_tid order", tex_tid, et);
      chk({tex_batch, tex_ip, tex_qmask} == {m_b[et], m_ip[et], m_q[et]}, "R3 tex fields",
          {tex_batch, tex_ip, tex_qmask}, {m_b[et], m_ip[et], m_q[et]});
    end
    // drive
    alloc_valid = ($urandom_range(0, 99) < apct);
    alloc_batch = BW'($urandom);
    alloc_ip    = IW'($urandom_range(0, 5));
    alloc_qmask = QW'($urandom_range(1, 15));
    alloc_op    = cls(alloc_batch, alloc_ip);
    alu_ready   = ($urandom_range(0, 99) < upct);
    tex_ready   = ($urandom_range(0, 99) < tpct);
    alu_next_op = (ea >= 0) ? cls(m_b[ea], m_ip[ea] + 1'b1) : 2'd0;
    tex_next_op = (et >= 0) ? cls(m_b[et], m_ip[et] + 1'b1) : 2'd0;
    d = rand_in(2);
    if ($urandom_range(0, 9) == 0) d = $urandom_range(0, N-1);  // possibly stray, R7
    texdone_valid = (d >= 0) && ($urandom_range(0, 99) < dpct);
    texdone_tid = TW'(d < 0 ? 0 : d);
    r = rand_in(3);
    if ($urandom_range(0, 9) == 0) r = $urandom_range(0, N-1);  // possibly stray, R9
    retire_valid = (r >= 0) && ($urandom_range(0, 99) < rpct);
    retire_tid = TW'(r < 0 ? 0 : r);
    if (retire_valid) last_ret = r;
    // model of the coming edge: predicates on the old table first
    af = alloc_valid && ef >= 0;
    uf = alu_ready && ea >= 0;
    tf = tex_ready && et >= 0;
    dk = texdone_valid && m_st[texdone_tid] == 2;
    rk = retire_valid && m_st[retire_tid] == 3;
    if (uf && any_wait()) overlap++;
    if (uf && prev_alu >= 0 && prev_alu != ea) switches++;
    prev_alu = uf ? ea : -1;
    if (dk) m_st[texdone_tid] = (m_op[texdone_tid][1]) ? 3 : 1;
    if (rk) m_st[retire_tid] = 0;
    if (af) begin
      m_st[ef] = alloc_op[1] ? 3 : 1; m_op[ef] = alloc_op;
      m_b[ef] = alloc_batch; m_ip[ef] = alloc_ip; m_q[ef] = alloc_qmask;
    end
    if (uf) begin
      m_ip[ea]++; m_op[ea] = alu_next_op; m_st[ea] = alu_next_op[1] ? 3 : 1;
      p_alu = (ea + 1) % N;
    end
    if (tf) begin
      m_ip[et]++; m_op[et] = tex_next_op; m_st[et] = 2;
      p_tex = (et + 1) % N;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ndone;
    void'($urandom(32'd2718));
    for (int i = 0; i < N; i++) m_st[i] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(alloc_ready == 1'b1, "R1 alloc_ready", alloc_ready, 1);
    chk(alloc_tid == '0, "R1 alloc_tid", alloc_tid, 0);
    chk(alu_valid == 1'b0 && tex_valid == 1'b0, "R1 issue idle", {alu_valid, tex_valid}, 0);
    // fill the table with both ports stalled
    repeat (N + 3) step(100, 0, 0, 0, 0);
    @(posedge clk); #1;
    chk(alloc_ready == 1'b0, "R2 full table", alloc_ready, 0);
    chk(alu_valid || tex_valid, "R10 offer held while stalled", {alu_valid, tex_valid}, 1);
    // drain every thread to done, allocation still requested, no retire
    repeat (200) step(100, 100, 100, 100, 0);
    @(posedge clk); #1;
    ndone = 0;
    for (int i = 0; i < N; i++) if (m_st[i] == 3) ndone++;
    chk(ndone == N, "R11 all done", ndone, N);
    chk(alloc_ready == 1'b0, "R11 no slot before retire", alloc_ready, 0);
    // retire together with a pending allocation
    last_ret = -1;
    while (last_ret < 0 || m_st[last_ret] != 0) step(100, 0, 0, 0, 100);
    @(posedge clk); #1;
    chk(alloc_ready == 1'b1, "R11 slot free after retire", alloc_ready, 1);
    chk(alloc_tid == TW'(last_ret), "R11 retired slot reused", alloc_tid, last_ret);
    // ALU busy, texture slow
    repeat (2000) step(40, 90, 15, 10, 40);
    // mixed random traffic
    repeat (6000) step(50, 75, 50, 35, 40);
    chk(overlap > 0, "R8 ALU issue during texture wait", overlap, 1);
    chk(switches > 0, "R5 back-to-back thread switch", switches, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule